// File: doc/BRIEF.md
# Write-Enable and Block-Protection Guard

This block decides whether a serial non-volatile memory may accept a write. It holds a write-enable latch, a two-bit block-protect field and a protect-enable bit. The command decoder feeds it opcode events, status-register data bytes and the end of each chip-select frame. The block answers with a write-permit for the array address that is being targeted, and with the status byte for status reads.

The latch is clear after reset. It is set by the write-enable command and cleared by the write-disable command. It is also cleared when a write command or a status-write command ends. The block-protect field marks a fixed fraction of the top of the array as read-only. When the protect-enable bit is set and the active-low write-protect pin is held low, status-register writes are refused. The array itself, the serial shifting and the power modes belong to other blocks.

Top module: `wp_guard`

## Requirements
- R1: After reset, `status` is 8'h00 and `wr_permit` is 0.
- R2: An opcode event with code 8'h06 sets the latch. The latch is `status` bit 1, and it reads 1 from the cycle after the event.
- R3: While the latch is clear, `wr_permit` is 0 for every address.
- R4: An opcode event with code 8'h04 clears the latch from the cycle after the event.
- R5: A `cs_rise` pulse clears the latch from the next cycle when the frame's command was a write (8'h02) or a status write (8'h01). After any other command, for example a status read (8'h05), the latch is unchanged. When `cs_rise` and `op_valid` occur in the same cycle, the opcode is ignored.
- R6: `wr_permit` follows `addr` in the same cycle and equals latch AND NOT protected. With BP = `status[3:2]`, the protected addresses are:
  - BP=00: none.
  - BP=01: the top quarter (`addr[17:16]` = 11).
  - BP=10: the top half (`addr[17]` = 1).
  - BP=11: every address.
- R7: A status data byte is accepted when all of the following hold: the frame's command is 8'h01, the latch is set, and the register is not locked. An accepted byte loads data bits 7 and 3:2 into the protect-enable bit (`status[7]`) and BP from the next cycle. Its other bits are ignored. A data byte that arrives in any other command frame is ignored.
- R8: A status data byte that arrives while the latch is clear leaves `status[7:2]` unchanged.
- R9: When `status[7]` = 1 and `wp_n` = 0, a status data byte leaves `status[7:2]` unchanged. If either condition is false, the byte is accepted as in R7.
- R10: `status` bits 6:4 and bit 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle pulse marking a decoded opcode |
| op_code | input | 8 | Opcode value, sampled while `op_valid` is high |
| sr_wr_valid | input | 1 | One-cycle pulse marking a status data byte |
| sr_wr_data | input | 8 | Status data byte |
| cs_rise | input | 1 | One-cycle pulse at the end of a chip-select frame |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | ADDR_W | Array address that is the target of a write |
| wr_permit | output | 1 | The current write byte may be stored |
| status | output | 8 | Status register read value |

## Verification
Opcode events, status data bytes and `cs_rise` pulses are driven on a falling edge and act on the next rising edge, so their effect on `status` is due one cycle later. The bench samples `status` on the falling edge that follows that rising edge. `wr_permit` is combinational from `addr` and the stored state, so the bench changes `addr` and samples `wr_permit` one nanosecond later, within the same cycle. At each of the four protect settings, the sweep covers every 1 KiB step of the address space and the addresses on either side of each region edge. The expected permit is computed from address ranges in the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [1:0] {CMD_IDLE, CMD_WRITE, CMD_WRSR, CMD_OTHER} cmd_e;

  // Protection decision from the BP field and the two top address bits.
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b11:   return 1'b1;
      2'b10:   return top2[1];
      2'b01:   return top2 == 2'b11;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp, input logic wel);
    return {wpen, 3'b000, bp, wel, 1'b0};
  endfunction
endpackage

// File: rtl/wp_cmd_track.sv
module wp_cmd_track
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       cs_rise,
  output cmd_e       cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= CMD_IDLE;
    end else if (cs_rise) begin
      cmd <= CMD_IDLE;
    end else if (op_valid) begin
      case (op_code)
        OP_WRITE: cmd <= CMD_WRITE;
        OP_WRSR:  cmd <= CMD_WRSR;
        default:  cmd <= CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/wp_latch.sv
module wp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (clr_evt) wel <= 1'b0;
    else if (set_evt) wel <= 1'b1;
  end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic [1:0] bp,
  output logic       wpen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp   <= 2'b00;
      wpen <= 1'b0;
    end else if (load) begin
      bp   <= data[3:2];
      wpen <= data[7];
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              sr_wr_valid,
  input  logic [7:0]        sr_wr_data,
  input  logic              cs_rise,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_permit,
  output logic [7:0]        status
);
  localparam int TOP = ADDR_W - 1;

  cmd_e       cmd;
  logic       wel;
  logic [1:0] bp;
  logic       wpen;

  // Named internal events.
  logic op_take;
  logic wel_set_evt;
  logic wel_clr_evt;
  logic sr_locked;
  logic sr_accept;
  logic addr_locked;

  assign op_take     = op_valid && !cs_rise;
  assign wel_set_evt = op_take && op_code == OP_WREN;
  assign wel_clr_evt = (op_take && op_code == OP_WRDI) ||
                       (cs_rise && (cmd == CMD_WRITE || cmd == CMD_WRSR));
  assign sr_locked   = wpen && !wp_n;
  assign sr_accept   = sr_wr_valid && !cs_rise && cmd == CMD_WRSR && wel && !sr_locked;
  assign addr_locked = region_locked(bp, addr[TOP -: 2]);

  wp_cmd_track u_cmd (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cs_rise(cs_rise), .cmd(cmd)
  );

  wp_latch u_wel (
    .clk(clk), .rst_n(rst_n), .set_evt(wel_set_evt), .clr_evt(wel_clr_evt), .wel(wel)
  );

  wp_status_reg u_sr (
    .clk(clk), .rst_n(rst_n), .load(sr_accept), .data(sr_wr_data), .bp(bp), .wpen(wpen)
  );

  assign wr_permit = wel && !addr_locked;
  assign status    = pack_status(wpen, bp, wel);
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] op_code,
  input logic       sr_wr_valid,
  input logic       cs_rise,
  input logic       wr_permit,
  input logic [7:0] status,
  input logic       sr_locked
);
  a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h06 && !cs_rise |=> status[1]);

  a_r4_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h04 && !cs_rise |=> !status[1]);

  a_r3_no_permit_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !wr_permit);

  a_r6_full_protect: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:2] == 2'b11 |-> !wr_permit);

  a_r8_clear_latch_blocks_sr: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_valid && !status[1] |=> $stable(status[7:2]));

  a_r9_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sr_locked |=> $stable(status[7:2]));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000 && !status[0]);
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .sr_wr_valid(sr_wr_valid), .cs_rise(cs_rise), .wr_permit(wr_permit),
  .status(status), .sr_locked(sr_locked)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;
  localparam int AW = 18;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          op_valid = 0;
  logic [7:0]    op_code = 0;
  logic          sr_wr_valid = 0;
  logic [7:0]    sr_wr_data = 0;
  logic          cs_rise = 0;
  logic          wp_n = 1;
  logic [AW-1:0] addr = 0;
  logic          wr_permit;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wp_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data), .cs_rise(cs_rise),
    .wp_n(wp_n), .addr(addr), .wr_permit(wr_permit), .status(status)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] c);
    @(negedge clk); op_valid = 1; op_code = c;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic sr_byte(input logic [7:0] d);
    @(negedge clk); sr_wr_valid = 1; sr_wr_data = d;
    @(negedge clk); sr_wr_valid = 0;
  endtask

  task automatic frame_end();
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic wrsr(input logic [7:0] d);
    op(8'h06); frame_end();
    op(8'h01); sr_byte(d); frame_end();
  endtask

  function automatic bit expect_permit(input bit wel, input int bp, input int a);
    bit prot;
    prot = (bp == 3) || (bp == 2 && a >= 'h20000) || (bp == 1 && a >= 'h30000);
    return wel && !prot;
  endfunction

  task automatic probe(input string req, input bit wel, input int bp, input int a);
    addr = AW'(a);
    #1;
    chk(req, int'(wr_permit), int'(expect_permit(wel, bp, a)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", int'(status), 0);
    chk("R1 permit", int'(wr_permit), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status after release", int'(status), 0);

    // R3: latch clear -> no permit anywhere
    for (int a = 0; a < 'h40000; a += 'h4000) probe("R3", 0, 0, a);

    // R2
    op(8'h06);
    chk("R2 latch set", int'(status), 8'h02);
    // R5: read-status frame leaves latch
    op(8'h05); frame_end();
    chk("R5 rdsr keeps latch", int'(status[1]), 1);
    // R7: byte outside a status-write frame ignored
    op(8'h05); sr_byte(8'h8C); frame_end();
    chk("R7 byte outside wrsr", int'(status), 8'h02);
    // R4
    op(8'h04);
    chk("R4 latch cleared", int'(status[1]), 0);

    // R6/R7 sweep over all BP settings
    for (int bp = 0; bp < 4; bp++) begin
      wrsr(8'h73 | 8'(bp << 2));
      chk("R7 load bp, junk bits dropped", int'(status), bp << 2);
      chk("R10 reserved bits", int'({status[6:4], status[0]}), 0);
      op(8'h06);
      for (int a = 0; a < 'h40000; a += 'h400) probe("R6 sweep", 1, bp, a);
      probe("R6 edge", 1, bp, 'h1FFFF);
      probe("R6 edge", 1, bp, 'h20000);
      probe("R6 edge", 1, bp, 'h2FFFF);
      probe("R6 edge", 1, bp, 'h30000);
      probe("R6 edge", 1, bp, 'h3FFFF);
      op(8'h02); frame_end();
      chk("R5 write frame clears latch", int'(status[1]), 0);
      probe("R3 after write frame", 0, bp, 0);
    end

    // R8: status byte with latch clear
    op(8'h01); sr_byte(8'h80); frame_end();
    chk("R8 ignored", int'(status), 8'h0C);

    // R9: lock
    wrsr(8'h84);
    chk("R9 setup wpen", int'(status), 8'h84);
    wp_n = 0;
    wrsr(8'h0C);
    chk("R9 locked unchanged", int'(status), 8'h84);
    wp_n = 1;
    wrsr(8'h88);
    chk("R9 pin high allows", int'(status), 8'h88);
    wrsr(8'h08);
    chk("R9 clear wpen", int'(status), 8'h08);
    wp_n = 0;
    wrsr(8'h04);
    chk("R9 wpen clear allows", int'(status), 8'h04);
    wp_n = 1;

    // R5: simultaneous cs_rise and opcode -> opcode ignored
    @(negedge clk); cs_rise = 1; op_valid = 1; op_code = 8'h06;
    @(negedge clk); cs_rise = 0; op_valid = 0;
    chk("R5 opcode with cs_rise ignored", int'(status[1]), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule